// File: doc/BRIEF.md
# Parallel Port Strobe and Handshake Controller

This block is a register-mapped parallel I/O unit with two byte-wide ports. Port C is bidirectional: each bit has its own direction bit, and the pins can be driven push-pull or open-drain. A separate capture register samples the port C pins on an active edge of the strobe input. Port B is output-only, and a strobe output accompanies it. A processor reaches five registers through a byte-wide bus with combinational read data. It can poll a status flag or take an interrupt when a byte has been captured.

The control register sets the operating mode. In simple strobed mode, each write to port B produces a fixed two-cycle strobe. In full input handshake mode, the strobe output acknowledges a captured byte. In full output handshake mode, the strobe output announces a new port B byte, and the peer's strobe edge acknowledges it. The strobe input and the port C pins pass through a two-flop synchronizer before the edge detector. Pins are modelled as separate output-data, output-enable and input signals per bit.

Register offsets on `bus_addr`:
- 0: control/status
- 1: port C data
- 2: port C direction
- 3: capture register (read-only)
- 4: port B

Top module: `pio_hs_unit`

## Requirements
- R1: After reset:
  - control reads 0x01;
  - direction reads 0x00;
  - `pc_oe` is 0x00;
  - `irq` is 0;
  - `stb_out` is 0, which is the idle level of the active-high strobe.
- R2: Control register bits, from bit 7 down to bit 0:
  - bit 7: capture flag;
  - bit 6: interrupt enable;
  - bit 5: open-drain;
  - bit 4: full handshake;
  - bit 3: output handshake;
  - bit 2: pulse select;
  - bit 1: rising-edge select;
  - bit 0: strobe polarity (1 = active-high).

  Bit 1 = 1 makes a rising `stb_in` edge active, and bit 1 = 0 makes a falling edge active. On an active edge, the synchronized `pc_in` value is copied into the capture register and the flag is set. An edge of the other direction changes neither.
- R3: The flag clears only after two reads in order: a control read made while the flag is 1, then a capture read. A capture read without that preceding control read leaves the flag set.
- R4: `irq` is 1 exactly when the flag and bit 6 are both 1.
- R5: With bit 4 = 0, a port B write makes `stb_out` active for two clock cycles, beginning at the write edge. With bit 0 = 0 the active level is low; with bit 0 = 1 it is high.
- R6: A direction bit of 1 drives that port C bit, and 0 releases it. A port C data read returns the data register for output bits and the synchronized pin for input bits.
- R7: With bit 5 = 1, an output bit drives 0 when its data is 0 and releases when its data is 1. `pc_out` is never 1 while driven.
- R8: Input handshake, level form (bits 4,3,2 = 1,0,0): an active `stb_in` edge makes `stb_out` active. It stays active until the flag-clearing capture read.
- R9: Output handshake, level form (bits 4,3,2 = 1,1,0): a port B write makes `stb_out` active. It stays active until an active `stb_in` edge, which also sets the flag.
- R10: In full handshake with bit 2 = 1, the triggering event gives a two-cycle `stb_out` pulse instead of a level.
- R11: Writes to control bit 7 and to the capture register have no effect. Every other register reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effects at the clock edge) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| pc_in | input | 8 | Port C pin input values |
| pc_out | output | 8 | Port C pin drive values |
| pc_oe | output | 8 | Port C per-bit drive enable |
| pb_out | output | 8 | Port B output |
| stb_in | input | 1 | Strobe input from the peer |
| stb_out | output | 1 | Strobe, ready or acknowledge output |
| irq | output | 1 | Interrupt request |

## Verification
Some properties are checked by assertions on every cycle:
- the flag rises after each detected edge;
- the flag survives until the two-step clear;
- the capture register stays frozen between edges;
- open-drain pins are never driven high, and input bits are never driven;
- a handshake level holds until its release event.

Other behaviour is shown only by the bench scenarios: the mapping of control bits to modes, the exact two-cycle pulse width under each polarity, the effect of edge-direction selection, and the synchronizer latency from pin to flag.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int BUS_W  = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_PDATA = 3'd1;
    localparam logic [ADDR_W-1:0] A_PDIR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAPT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_OUTP  = 3'd4;

    // writable control bits; bit order is the software-visible layout
    typedef struct packed {
        logic irq_en;
        logic open_drain;
        logic full_hs;
        logic out_hs;
        logic pulse_sel;
        logic rise_edge;
        logic strobe_pol;
    } pio_cfg_t;

    localparam pio_cfg_t CFG_RST = '{strobe_pol: 1'b1, default: 1'b0};

    typedef enum logic [1:0] {
        HS_SIMPLE = 2'd0,
        HS_INPUT  = 2'd1,
        HS_OUTPUT = 2'd2
    } hs_mode_e;

    function automatic hs_mode_e decode_mode(input pio_cfg_t c);
        if (!c.full_hs)
            return HS_SIMPLE;
        return c.out_hs ? HS_OUTPUT : HS_INPUT;
    endfunction
endpackage

// File: rtl/pio_sync_edge.sv
module pio_sync_edge #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pins,
    input  logic         stb,
    input  logic         rise_sel,
    output logic [W-1:0] pins_sync,
    output logic         edge_hit
);
    logic [STAGES-1:0] stb_sh;
    logic              stb_prev;
    logic [W-1:0]      pin_sh [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_sh   <= '0;
            stb_prev <= 1'b0;
            for (int i = 0; i < STAGES; i++)
                pin_sh[i] <= '0;
        end else begin
            stb_sh   <= {stb_sh[STAGES-2:0], stb};
            stb_prev <= stb_sh[STAGES-1];
            pin_sh[0] <= pins;
            for (int i = 1; i < STAGES; i++)
                pin_sh[i] <= pin_sh[i-1];
        end
    end

    assign pins_sync = pin_sh[STAGES-1];
    assign edge_hit  = rise_sel ? ( stb_sh[STAGES-1] & ~stb_prev)
                                : (~stb_sh[STAGES-1] &  stb_prev);
endmodule

// File: rtl/pio_pin_drv.sv
module pio_pin_drv #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] data,
    input  logic         open_drain,
    output logic [W-1:0] pc_out,
    output logic [W-1:0] pc_oe
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_comb begin
            if (open_drain) begin
                pc_out[b] = 1'b0;
                pc_oe[b]  = dir[b] & ~data[b];
            end else begin
                pc_out[b] = data[b];
                pc_oe[b]  = dir[b];
            end
        end
    end

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        open_drain |-> ((pc_oe & pc_out) == '0)); // R7
    AST_INPUT_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (pc_oe & ~dir) == '0); // R6
endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
    import pio_pkg::*;
#(
    parameter int PULSE_LEN = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  hs_mode_e mode,
    input  logic     pulse_sel,
    input  logic     pol,
    input  logic     wr_out,
    input  logic     in_edge,
    input  logic     flag_clr,
    output logic     stb_out
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);

    logic             hold_q;
    logic [CNT_W-1:0] cnt_q;
    logic             trig, rel, pulse_mode, act;

    always_comb begin
        pulse_mode = (mode == HS_SIMPLE) || pulse_sel;
        unique case (mode)
            HS_INPUT:  begin trig = in_edge; rel = flag_clr; end
            HS_OUTPUT: begin trig = wr_out;  rel = in_edge;  end
            default:   begin trig = wr_out;  rel = 1'b0;     end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (pulse_mode)  hold_q <= 1'b0;
            else if (trig)   hold_q <= 1'b1;
            else if (rel)    hold_q <= 1'b0;

            if (pulse_mode && trig) cnt_q <= CNT_W'(PULSE_LEN);
            else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
        end
    end

    assign act     = hold_q | (cnt_q != '0);
    assign stb_out = pol ? act : ~act;

    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (rst)
        (pulse_mode && trig) |=> (stb_out == $past(pol))); // R5
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (hold_q && !pulse_mode && !rel) |=> hold_q); // R8
endmodule

// File: rtl/pio_hs_unit.sv
module pio_hs_unit
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [BUS_W-1:0]  pc_in,
    output logic [BUS_W-1:0]  pc_out,
    output logic [BUS_W-1:0]  pc_oe,
    output logic [BUS_W-1:0]  pb_out,
    input  logic              stb_in,
    output logic              stb_out,
    output logic              irq
);
    pio_cfg_t         cfg_q;
    logic [BUS_W-1:0] dir_q, dat_q, capt_q, outp_q, pins_s;
    logic             flag_q, arm_q, edge_hit;
    logic             wr_en, rd_en, rd_ctrl, rd_capt, flag_clr;

    assign wr_en    = bus_sel & bus_wr;
    assign rd_en    = bus_sel & bus_rd;
    assign rd_ctrl  = rd_en && bus_addr == A_CTRL;
    assign rd_capt  = rd_en && bus_addr == A_CAPT;
    assign flag_clr = arm_q & rd_capt;

    pio_sync_edge #(.W(BUS_W), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .pins(pc_in), .stb(stb_in),
        .rise_sel(cfg_q.rise_edge), .pins_sync(pins_s), .edge_hit(edge_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RST;
            dir_q  <= '0;
            dat_q  <= '0;
            outp_q <= '0;
        end else if (wr_en) begin
            unique case (bus_addr)
                A_CTRL:  cfg_q  <= pio_cfg_t'(bus_wdata[6:0]);
                A_PDATA: dat_q  <= bus_wdata;
                A_PDIR:  dir_q  <= bus_wdata;
                A_OUTP:  outp_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            capt_q <= '0;
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            if (edge_hit) capt_q <= pins_s;
            if (edge_hit)      flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
            if (flag_clr)                arm_q <= 1'b0;
            else if (rd_ctrl && flag_q)  arm_q <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            unique case (bus_addr)
                A_CTRL:  bus_rdata = {flag_q, cfg_q};
                A_PDATA: bus_rdata = (dat_q & dir_q) | (pins_s & ~dir_q);
                A_PDIR:  bus_rdata = dir_q;
                A_CAPT:  bus_rdata = capt_q;
                A_OUTP:  bus_rdata = outp_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    pio_pin_drv #(.W(BUS_W)) u_pins (
        .clk(clk), .rst(rst), .dir(dir_q), .data(dat_q),
        .open_drain(cfg_q.open_drain), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    pio_strobe_gen #(.PULSE_LEN(2)) u_strobe (
        .clk(clk), .rst(rst), .mode(decode_mode(cfg_q)),
        .pulse_sel(cfg_q.pulse_sel), .pol(cfg_q.strobe_pol),
        .wr_out(wr_en && bus_addr == A_OUTP), .in_edge(edge_hit),
        .flag_clr(flag_clr), .stb_out(stb_out)
    );

    assign pb_out = outp_q;
    assign irq    = flag_q & cfg_q.irq_en;

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
        edge_hit |=> flag_q); // R2
    AST_CAPT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !edge_hit |=> $stable(capt_q)); // R2
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !rd_capt) |=> flag_q); // R3
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !edge_hit) |=> !flag_q); // R3
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag_q); // R4
endmodule

// File: tb/tb_pio_hs_unit.sv
`timescale 1ns/1ps
module tb_pio_hs_unit;
    localparam logic [2:0] CTRL = 3'd0, PDAT = 3'd1, PDIR = 3'd2, CAPT = 3'd3, OUTP = 3'd4;

    // {addr, write data, expected read-back}
    localparam int NV = 7;
    localparam logic [18:0] VEC [NV] = '{
        {CTRL, 8'hFF, 8'h7F},
        {CTRL, 8'h01, 8'h01},
        {PDIR, 8'h3C, 8'h3C},
        {PDIR, 8'hFF, 8'hFF},
        {OUTP, 8'h96, 8'h96},
        {PDAT, 8'h5A, 8'h5A},
        {PDIR, 8'h00, 8'h00}
    };

    logic       clk = 1'b0, rst = 1'b1;
    logic       bus_sel = 0, bus_wr = 0, bus_rd = 0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata, pc_in = '0, pc_out, pc_oe, pb_out;
    logic       stb_in = 1'b0, stb_out, irq;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;
    logic [7:0] v;

    always #4 clk = ~clk;

    pio_hs_unit dut (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 0; bus_rd = 0;
    endtask

    task automatic set_stb(input logic lv);
        @(negedge clk);
        stb_in = lv;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic step;
        @(posedge clk); #1;
    endtask

    task automatic finish_run;
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        rd(CTRL, v); chk("R1 ctrl", v, 8'h01);
        rd(PDIR, v); chk("R1 dir", v, 8'h00);
        chk("R1 pc_oe", pc_oe, 8'h00);
        chk("R1 stb_out", {7'd0, stb_out}, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R11 register table walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][18:16], VEC[i][15:8]);
            rd(VEC[i][18:16], v);
            chk("R11 readback", v, VEC[i][7:0]);
        end
        chk("R11 pb_out", pb_out, 8'h96);
        wr(CAPT, 8'hEE); rd(CAPT, v); chk("R11 capt write ignored", v, 8'h00);

        // R6 direction and mixed read
        pc_in = 8'h0F;
        wr(PDIR, 8'hA5); wr(PDAT, 8'hFF);
        step(); step();
        chk("R6 pc_oe", pc_oe, 8'hA5);
        chk("R6 pc_out", pc_out & pc_oe, 8'hA5);
        rd(PDAT, v); chk("R6 mixed read", v, 8'hAF);

        // R7 open drain
        wr(CTRL, 8'h21); wr(PDIR, 8'hFF); wr(PDAT, 8'h0F);
        chk("R7 od oe", pc_oe, 8'hF0);
        chk("R7 od out", pc_out, 8'h00);
        wr(CTRL, 8'h01); wr(PDIR, 8'h00);

        // R5 simple strobe, active-high then active-low
        wr(OUTP, 8'h11);
        chk("R5 hi c1", {7'd0, stb_out}, 8'h01); step();
        chk("R5 hi c2", {7'd0, stb_out}, 8'h01); step();
        chk("R5 hi end", {7'd0, stb_out}, 8'h00);
        wr(CTRL, 8'h00);
        chk("R5 lo idle", {7'd0, stb_out}, 8'h01);
        wr(OUTP, 8'h22);
        chk("R5 lo c1", {7'd0, stb_out}, 8'h00); step();
        chk("R5 lo c2", {7'd0, stb_out}, 8'h00); step();
        chk("R5 lo end", {7'd0, stb_out}, 8'h01);

        // R2 rising capture, R3 clear sequence
        wr(CTRL, 8'h03);
        pc_in = 8'h5A; set_stb(1);
        rd(CTRL, v); chk("R2 flag set", v, 8'h83);
        rd(CAPT, v); chk("R2 captured", v, 8'h5A);
        rd(CTRL, v); chk("R3 cleared", v, 8'h03);
        set_stb(0);
        rd(CTRL, v); chk("R2 wrong edge ignored", v, 8'h03);
        pc_in = 8'h33; set_stb(1);
        rd(CAPT, v); chk("R2 capture 2", v, 8'h33);
        rd(CTRL, v); chk("R3 capt read alone keeps flag", v, 8'h83);
        // R4 interrupt
        chk("R4 irq off", {7'd0, irq}, 8'h00);
        wr(CTRL, 8'h43);
        chk("R4 irq on", {7'd0, irq}, 8'h01);
        rd(CAPT, v);
        chk("R4 irq drops", {7'd0, irq}, 8'h00);
        // falling select
        wr(CTRL, 8'h01);
        pc_in = 8'hC3; set_stb(0);
        rd(CTRL, v); chk("R2 falling edge", v, 8'h81);
        rd(CAPT, v); chk("R2 falling data", v, 8'hC3);

        // R8 input handshake level
        wr(CTRL, 8'h13);
        chk("R8 idle", {7'd0, stb_out}, 8'h00);
        pc_in = 8'h77; set_stb(1);
        chk("R8 ack active", {7'd0, stb_out}, 8'h01);
        rd(CTRL, v); step();
        chk("R8 still active", {7'd0, stb_out}, 8'h01);
        rd(CAPT, v);
        chk("R8 released", {7'd0, stb_out}, 8'h00);

        // R9 output handshake level
        wr(CTRL, 8'h1B);
        set_stb(0);
        wr(OUTP, 8'h77);
        chk("R9 ready", {7'd0, stb_out}, 8'h01);
        repeat (4) step();
        chk("R9 held", {7'd0, stb_out}, 8'h01);
        set_stb(1);
        chk("R9 acked", {7'd0, stb_out}, 8'h00);
        rd(CTRL, v); chk("R9 flag", v, 8'h9B);
        rd(CAPT, v);

        // R10 pulse form in full handshake
        wr(CTRL, 8'h1F);
        wr(OUTP, 8'h55);
        chk("R10 c1", {7'd0, stb_out}, 8'h01); step();
        chk("R10 c2", {7'd0, stb_out}, 8'h01); step();
        chk("R10 end", {7'd0, stb_out}, 8'h00);

        finish_run();
    end
endmodule